// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Controller

This block is the host side of a serial daisy chain of N converters, each producing a 16-bit result. On a start request it raises the convert line while the serial clock is high, which puts the chain into chained operation with a completion signal. It then holds convert high and watches the serial data line coming back from the converter closest to the host. When that line goes from low to high, every converter in the chain has finished. This edge acts as the ready interrupt.

After the ready edge the controller produces 16×N+1 serial clock pulses. It samples the data line on each falling edge and drops the first sample, which is only the ready flag. The remaining 16×N bits are assembled into N words and shown on a flat output bus, together with a one-cycle valid strobe. If the ready edge does not come within a set number of cycles, the controller gives up and raises a one-cycle timeout strobe. The chain length, the clock divider and the timeout are parameters.

Top module: `chain_rdbk_ctrl`

## Requirements
- R1: After synchronous reset, `cnv_o` is low, `sck_o` is high, `valid_o` and `timeout_o` are low, and `words_o` is all zero.
- R2: A high `start_i` seen in idle raises `cnv_o` on the next clock edge. `sck_o` is high at that moment.
- R3: `cnv_o` stays high without a break from its rise until the cycle in which `valid_o` or `timeout_o` is shown.
- R4: While waiting, `sck_o` stays high. Readback starts only after `sdo_i` is sampled low and then high on consecutive clock edges.
- R5: A readback produces exactly 16×N_DEV+1 falling edges on `sck_o`. Each half period of `sck_o` lasts SCK_DIV clock cycles.
- R6: At each falling edge the controller captures the value `sdo_i` had just before that edge. The first captured bit (the ready flag) is discarded.
- R7: Word k of `words_o` (bits [16k+15:16k]) holds the k-th group of 16 captured bits after the flag, MSB first. Word 0 comes from the converter nearest the host.
- R8: On completion `cnv_o` goes low, `sck_o` is high and `valid_o` is high for exactly one cycle, all in the same cycle. `words_o` then holds its value until the next completion.
- R9: If no ready edge is seen within TIMEOUT_CYC cycles of `cnv_o` rising, then in cycle TIMEOUT_CYC `timeout_o` pulses for one cycle and `cnv_o` goes low. No `valid_o` is produced and `words_o` is unchanged.
- R10: A `start_i` that arrives while a conversion or readback is in progress has no effect. No new conversion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and readback |
| sdo_i | input | 1 | Serial data / ready flag from the nearest converter |
| cnv_o | output | 1 | Convert line to all converters |
| sck_o | output | 1 | Serial clock to all converters, idles high |
| words_o | output | 16×N_DEV | Received words, word k at bits [16k+15:16k] |
| valid_o | output | 1 | One-cycle strobe: `words_o` has been updated |
| timeout_o | output | 1 | One-cycle strobe: ready edge missing, transfer aborted |

## Verification
A bit counter that slips by one shows up at the ports in two ways. First, a wrong number of falling clock edges in the very burst where it happens. Second, every word shifted by one bit position at the valid strobe of that same transfer. A wrong state, or a ready-edge detector that fires early, shows as clock edges while the converter model is not ready, or as convert dropping before any strobe. Either is visible within a few cycles. A broken timeout counter moves the timeout strobe away from exactly TIMEOUT_CYC cycles after convert rises. A start request that leaks through while busy raises convert again within one cycle after completion.

// File: rtl/chain_rdbk_pkg.sv
package chain_rdbk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } rdbk_state_t;
endpackage

// File: rtl/chain_sck_gen.sv
// Serial clock generator: idles high, toggles every HALF_CYC cycles when enabled.
module chain_sck_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sck,
  output logic fall,
  output logic rise
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick = en && (div_q == DW'(HALF_CYC - 1));
  assign fall = tick && sck;
  assign rise = tick && !sck;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q <= '0;
      sck   <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      sck   <= ~sck;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/chain_shift_rx.sv
// Falling-edge capture: counts edges, drops the first bit, shifts the rest in MSB first.
module chain_shift_rx #(
  parameter int NBITS = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             fall,
  input  logic             din,
  output logic [NBITS-1:0] data,
  output logic             done
);
  localparam int NFALL = NBITS + 1;
  localparam int CW    = $clog2(NFALL + 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == CW'(NFALL));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (fall && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
    end else if (fall && !done && (cnt_q != '0)) begin
      data <= {data[NBITS-2:0], din};
    end
  end
endmodule

// File: rtl/chain_tmo_cnt.sv
// Cycle counter flagging the last cycle of the ready wait window.
module chain_tmo_cnt #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;

  assign expired = en && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/chain_rdbk_ctrl.sv
module chain_rdbk_ctrl #(
  parameter int N_DEV       = 3,
  parameter int WORD_W      = 16,
  parameter int SCK_DIV     = 2,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    sdo_i,
  output logic                    cnv_o,
  output logic                    sck_o,
  output logic [N_DEV*WORD_W-1:0] words_o,
  output logic                    valid_o,
  output logic                    timeout_o
);
  import chain_rdbk_pkg::*;

  localparam int NBITS = N_DEV * WORD_W;

  rdbk_state_t      state_q;
  logic             sdo_prev_q;
  logic             ready_edge;
  logic             gen_en;
  logic             sck_fall;
  logic             sck_rise;
  logic             rx_done;
  logic             tmo_hit;
  logic             finish;
  logic [NBITS-1:0] rx_data;
  logic [NBITS-1:0] rx_words;

  assign gen_en     = (state_q == ST_READ);
  assign ready_edge = (state_q == ST_CONV) && sdo_i && !sdo_prev_q;
  assign finish     = gen_en && rx_done && sck_rise;

  chain_sck_gen #(.HALF_CYC(SCK_DIV)) u_sck (
    .clk (clk),
    .rst (rst),
    .en  (gen_en),
    .sck (sck_o),
    .fall(sck_fall),
    .rise(sck_rise)
  );

  chain_shift_rx #(.NBITS(NBITS)) u_rx (
    .clk (clk),
    .rst (rst),
    .clr (state_q != ST_READ),
    .fall(sck_fall),
    .din (sdo_i),
    .data(rx_data),
    .done(rx_done)
  );

  chain_tmo_cnt #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk    (clk),
    .rst    (rst),
    .clr    (state_q != ST_CONV),
    .en     (state_q == ST_CONV),
    .expired(tmo_hit)
  );

  // First word received belongs to the nearest converter: it sits at the top of the shifter.
  for (genvar k = 0; k < N_DEV; k++) begin : g_word
    assign rx_words[k*WORD_W +: WORD_W] = rx_data[(N_DEV-1-k)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sdo_prev_q <= 1'b0;
      cnv_o      <= 1'b0;
      valid_o    <= 1'b0;
      timeout_o  <= 1'b0;
      words_o    <= '0;
    end else begin
      sdo_prev_q <= sdo_i;
      valid_o    <= 1'b0;
      timeout_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnv_o   <= 1'b1;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (ready_edge) begin
            state_q <= ST_READ;
          end else if (tmo_hit) begin
            cnv_o     <= 1'b0;
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_READ: begin
          if (finish) begin
            cnv_o   <= 1'b0;
            valid_o <= 1'b1;
            words_o <= rx_words;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_rdbk_chk.sv
module chain_rdbk_chk #(
  parameter int N_DEV  = 3,
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic cnv_o,
  input logic sck_o,
  input logic valid_o,
  input logic timeout_o
);
  localparam int NFALL = N_DEV * WORD_W + 1;
  localparam int CW    = $clog2(NFALL + 2);

  logic          sck_prev_q;
  logic [CW-1:0] falls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev_q <= 1'b1;
      falls_q    <= '0;
    end else begin
      sck_prev_q <= sck_o;
      if (!cnv_o) falls_q <= '0;
      else if (sck_prev_q && !sck_o) falls_q <= falls_q + 1'b1;
    end
  end

  // R2
  sck_high_at_cnv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> sck_o);

  // R10
  cnv_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> $past(start_i));

  // R3
  cnv_held_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_o) |-> (valid_o || timeout_o));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && timeout_o));

  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cnv_o |-> sck_o);

  // R5
  fall_count_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (falls_q == CW'(NFALL)));
endmodule

bind chain_rdbk_ctrl chain_rdbk_chk #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .cnv_o    (cnv_o),
  .sck_o    (sck_o),
  .valid_o  (valid_o),
  .timeout_o(timeout_o)
);

// File: tb/chain_rdbk_ctrl_bench.sv
`timescale 1ns/1ps
module chain_rdbk_ctrl_bench;
  localparam int N   = 3;
  localparam int W   = 16;
  localparam int DIV = 2;
  localparam int TMO = 300;
  localparam int NB  = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          sdo_i;
  logic          cnv_o, sck_o, valid_o, timeout_o;
  logic [NB-1:0] words_o;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  chain_rdbk_ctrl #(.N_DEV(N), .WORD_W(W), .SCK_DIV(DIV), .TIMEOUT_CYC(TMO)) u_chain_rdbk_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .sdo_i(sdo_i),
    .cnv_o(cnv_o), .sck_o(sck_o), .words_o(words_o),
    .valid_o(valid_o), .timeout_o(timeout_o)
  );

  // Behavioural chain: ready flag followed by all words, shifted on sck falling edges.
  logic [NB:0]  mreg   = '0;
  logic         mready = 1'b0;
  logic [W-1:0] dat [N];
  assign sdo_i = mready & mreg[NB];

  int  falls = 0, pre_falls = 0, period_bad = 0;
  time last_fall = 0;
  logic sck_at_rise = 1'b0;

  always @(negedge sck_o) begin
    if (mready) mreg <= mreg << 1;
    else pre_falls++;
    if (falls > 0 && ($time - last_fall) != time'(2*DIV*10)) period_bad++;
    last_fall = $time;
    falls++;
  end

  always @(posedge cnv_o) sck_at_rise = sck_o;

  function automatic logic [NB-1:0] exp_words();
    logic [NB-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = dat[k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [NB-1:0] last_words = '0;

  task automatic run(input int delay, input bit never, input int busy_at);
    int cyc;
    bit cnv_drop;
    cnv_drop = 0;
    falls = 0; pre_falls = 0; period_bad = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(cnv_o === 1'b1 && sck_at_rise === 1'b1, "R2 cnv up with sck high", {cnv_o, sck_at_rise}, 2'b11);
    cyc = 0;
    while (cyc < 5000) begin
      cyc++;
      if (cyc == delay && !never) begin
        mreg = '0;
        mreg[NB] = 1'b1;
        for (int k = 0; k < N; k++) mreg[NB-1-k*W -: W] = dat[k];
        mready = 1'b1;
      end
      start_i = (cyc == busy_at);
      @(negedge clk);
      if (valid_o || timeout_o) break;
      if (!cnv_o) cnv_drop = 1;
    end
    start_i = 1'b0;
    chk(!cnv_drop, "R3 cnv held until strobe", cnv_drop, 0);
    if (never) begin
      chk(timeout_o === 1'b1 && valid_o === 1'b0, "R9 timeout strobe", {timeout_o, valid_o}, 2'b10);
      chk(cyc == TMO, "R9 timeout cycle", cyc, TMO);
      chk(cnv_o === 1'b0, "R9 cnv low", cnv_o, 0);
      chk(words_o === last_words, "R9 words kept", words_o, last_words);
      chk(falls == 0, "R4 no sck without ready", falls, 0);
    end else begin
      chk(valid_o === 1'b1 && timeout_o === 1'b0, "R8 valid strobe", {valid_o, timeout_o}, 2'b10);
      chk(cnv_o === 1'b0 && sck_o === 1'b1, "R8 cnv low sck high", {cnv_o, sck_o}, 2'b01);
      chk(words_o === exp_words(), "R7 R6 words", words_o, exp_words());
      chk(falls == NB + 1, "R5 falling edge count", falls, NB + 1);
      chk(period_bad == 0, "R5 half period", period_bad, 0);
      chk(pre_falls == 0, "R4 sck idle before ready", pre_falls, 0);
      last_words = exp_words();
    end
    mready = 1'b0;
    @(negedge clk);
    chk(valid_o === 1'b0 && timeout_o === 1'b0, "R8 one-cycle strobe", {valid_o, timeout_o}, 0);
    chk(words_o === last_words, "R8 words held", words_o, last_words);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cnv_o !== 1'b0) begin
        chk(0, "R10 busy start ignored", cnv_o, 0);
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0DE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cnv_o === 1'b0 && sck_o === 1'b1 && !valid_o && !timeout_o && words_o === '0,
        "R1 reset state", {cnv_o, sck_o, valid_o, timeout_o}, 4'b0100);
    // directed patterns
    for (int k = 0; k < N; k++) dat[k] = 16'hFFFF;
    run(3, 0, 2);
    for (int k = 0; k < N; k++) dat[k] = 16'h0000;
    run(TMO - 10, 0, 100);
    for (int k = 0; k < N; k++) dat[k] = (k % 2) ? 16'h5A5A : 16'h8001;
    run(20, 0, 60);
    run(0, 1, 150);
    for (int k = 0; k < N; k++) dat[k] = 16'h0001 << k;
    run(5, 0, 0);
    // random runs
    for (int r = 0; r < 20; r++) begin
      int d;
      for (int k = 0; k < N; k++) dat[k] = 16'($urandom);
      d = 3 + int'($urandom % 200);
      if (r % 7 == 3) run(0, 1, 1 + int'($urandom % 250));
      else run(d, 0, (r % 2) ? d + 30 : 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule